// File: doc/BRIEF.md
# Windowed Rolling-Shutter Scan Sequencer

This block paces the readout of a rolling-shutter pixel array from a single master clock. A row period is a fixed count of clocks. The frame is a run of such row periods. In every row period the block names one row to be read, column by column, and one row whose integration is to start. The read row and the reset row are a set number of rows apart, so that number is the exposure time, counted in row periods. The frame length depends on a virtual frame depth and width rather than on the window size. This lets the frame rate be lowered without changing the clock.

Two modes are provided. In free-running mode, frames follow each other until a stop request is seen at a frame boundary. In triggered mode, a sync pulse starts one sequence. That sequence first starts the integration of the window rows, then reads them out, and then the block waits for the next sync. A strobe output, when enabled, marks the span in triggered mode where every window row is integrating and no read is close.

All geometry is captured when a frame starts, so a write made during a frame takes effect only at the next frame. Subsampling drops whole 2x2 colour tiles in each direction.

Top module: `woi_scan_gen`

## Requirements
- R1: A row period lasts Weff + shs_width + shr_width + 19 clocks, where Weff = max(virt_width, win_width). A free-running frame lasts (Deff + 1) row periods, where Deff = max(virt_depth, win_height). frame_done is high for exactly the last clock of each frame.
- R2: When the virtual width or depth is smaller than the window width or height, the window value is used in its place for the period arithmetic of R1.
- R3: A read of window row offset r, column offset c has rd_en high with row_addr = win_row_start + r and col_addr = win_col_start + c. The column offsets occupy clocks 0 to win_width-1 of the row period. While rd_en is low, both address outputs are 0.
- R4: For a 2-bit skip factor f, an offset k is kept when bits f..1 of k are all zero. So f=0 keeps every offset, f=1 keeps a 2-offset tile and drops the next, f=2 keeps 1 tile of 4, and f=3 keeps 1 tile of 8. row_skip applies this to rows (reads and resets) and col_skip applies it to columns.
- R5: In free-running mode, row period g carries a one-clock rst_en in its first clock, with rst_row = win_row_start + ((g + I) mod (Deff+1)). I is int_rows clamped to Deff, and the pulse is given only when that offset lies inside the window and is kept by row_skip. Row period g reads offset g.
- R6: In free-running mode, an idle block starts a frame on the clock after stop_req is seen low, and frames follow back to back with no gap.
- R7: A stop request ends output only at the end of the frame in progress. After that frame's frame_done, rd_en and rst_en stay low.
- R8: In triggered mode, sync_in seen while idle starts one sequence of int_rows + Deff + 1 row periods. Row period g resets offset g and reads offset g - int_rows. The block then idles. A sync_in pulse during a sequence is ignored.
- R9: With strobe_en set in triggered mode, strobe is high throughout row periods g with win_height <= g < int_rows - 1, and low everywhere else. With strobe_en clear, strobe stays low.
- R10: All window, virtual-size, sample-width, skip, exposure, mode and strobe-enable inputs are sampled only when a frame starts. Changes made during a frame do not alter that frame.
- R11: While rst is high and after it falls, the block is idle with all outputs low until a start condition of R6 or R8 occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| win_row_start | input | 11 | First window row |
| win_col_start | input | 11 | First window column |
| win_height | input | 11 | Window height in rows |
| win_width | input | 11 | Window width in columns |
| virt_depth | input | 11 | Virtual frame depth (frame has depth+1 rows) |
| virt_width | input | 11 | Virtual row width in clocks |
| shs_width | input | 8 | Signal sample-hold width in clocks |
| shr_width | input | 8 | Reset sample-hold width in clocks |
| row_skip | input | 2 | Row tile skip factor |
| col_skip | input | 2 | Column tile skip factor |
| int_rows | input | 13 | Exposure in row periods |
| single_mode | input | 1 | 1 = triggered single sequence, 0 = free-running |
| strobe_en | input | 1 | Enables the strobe output in triggered mode |
| sync_in | input | 1 | Trigger for triggered mode |
| stop_req | input | 1 | Stop at end of current frame / hold idle |
| rd_en | output | 1 | Pixel read enable |
| row_addr | output | 11 | Row being read |
| col_addr | output | 11 | Column being read |
| rst_en | output | 1 | One-clock pulse starting integration of a row |
| rst_row | output | 11 | Row whose integration starts |
| frame_done | output | 1 | High in the last clock of a frame |
| strobe | output | 1 | Illumination strobe window |

## Verification
The bench targets four corner cases.
- The wrap of the reset pointer across the frame end in free-running mode: a design that does not wrap would drop the reset pulses that prepare the next frame's first rows.
- Virtual sizes smaller than the window and an exposure larger than the frame: getting these wrong would show up as a wrong frame period or as a reset row outside the window.
- A stop request and a geometry write made during a frame: a design that acted on them at once would truncate the frame or read it with a mixed geometry.
- A second sync during a triggered sequence, and the strobe limits: a design that restarted on the sync would emit unexpected reads, and one with an off-by-one on the strobe bound would miscount the strobe clocks by a full row period.

// File: rtl/woi_pkg.sv
package woi_pkg;

    localparam int ROW_W   = 11;           // row address / height width
    localparam int COL_W   = 11;           // column address / width width
    localparam int SH_W    = 8;            // sample-hold width field
    localparam int INT_W   = 13;           // exposure field
    localparam int PER_W   = COL_W + 2;    // row-period clock counter
    localparam int SEQ_W   = INT_W + 1;    // row index within a sequence
    localparam int ROW_OVH = 19;           // fixed clocks per row period

    typedef enum logic {
        ST_IDLE,
        ST_RUN
    } scan_st_e;

    // geometry as captured at a frame start, only what the scan needs
    typedef struct packed {
        logic [ROW_W-1:0] row_start;
        logic [COL_W-1:0] col_start;
        logic [ROW_W-1:0] height;
        logic [COL_W-1:0] width;
        logic [1:0]       sub_row;
        logic [1:0]       sub_col;
        logic             single;
        logic             strobe_on;
    } scan_geom_t;

    function automatic logic [SEQ_W-1:0] larger_of(input logic [SEQ_W-1:0] a,
                                                   input logic [SEQ_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

    // tile keep test: bits f..1 of the offset must be zero
    function automatic logic tile_keep(input logic [3:0] off, input logic [1:0] f);
        case (f)
            2'd0:    return 1'b1;
            2'd1:    return off[1] == 1'b0;
            2'd2:    return off[2:1] == 2'b00;
            default: return off[3:1] == 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/woi_cfg_latch.sv
module woi_cfg_latch
    import woi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ROW_W-1:0] row_start,
    input  logic [COL_W-1:0] col_start,
    input  logic [ROW_W-1:0] height,
    input  logic [COL_W-1:0] width,
    input  logic [ROW_W-1:0] depth,
    input  logic [COL_W-1:0] vwidth,
    input  logic [SH_W-1:0]  shs,
    input  logic [SH_W-1:0]  shr,
    input  logic [1:0]       sub_row,
    input  logic [1:0]       sub_col,
    input  logic [INT_W-1:0] int_rows,
    input  logic             single,
    input  logic             strobe_on,
    output scan_geom_t       geom_q,
    output logic [SEQ_W-1:0] rows_q,
    output logic [SEQ_W-1:0] seq_len_q,
    output logic [SEQ_W-1:0] int_q,
    output logic [PER_W-1:0] period_q
);

    logic [SEQ_W-1:0] dep_eff, wid_eff, rows_n, int_raw, int_n, seq_n;
    logic [PER_W-1:0] period_n;
    scan_geom_t       geom_n;

    always_comb begin
        dep_eff  = larger_of(SEQ_W'(depth), SEQ_W'(height));
        wid_eff  = larger_of(SEQ_W'(vwidth), SEQ_W'(width));
        rows_n   = dep_eff + SEQ_W'(1);
        int_raw  = SEQ_W'(int_rows);
        // free-running: exposure cannot exceed one frame less a row
        int_n    = (!single && int_raw > dep_eff) ? dep_eff : int_raw;
        seq_n    = single ? (int_n + rows_n) : rows_n;
        period_n = PER_W'(wid_eff) + PER_W'(shs) + PER_W'(shr) + PER_W'(ROW_OVH);
        geom_n   = '{row_start: row_start, col_start: col_start,
                     height: height, width: width,
                     sub_row: sub_row, sub_col: sub_col,
                     single: single, strobe_on: strobe_on};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            geom_q    <= '0;
            rows_q    <= SEQ_W'(1);
            seq_len_q <= SEQ_W'(1);
            int_q     <= '0;
            period_q  <= PER_W'(ROW_OVH);
        end else if (load) begin
            geom_q    <= geom_n;
            rows_q    <= rows_n;
            seq_len_q <= seq_n;
            int_q     <= int_n;
            period_q  <= period_n;
        end
    end

endmodule

// File: rtl/woi_col_timer.sv
module woi_col_timer
    import woi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [PER_W-1:0] period,
    output logic [PER_W-1:0] col_cnt,
    output logic             row_end
);

    assign row_end = run && (col_cnt == period - PER_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run)  col_cnt <= '0;
        else if (row_end) col_cnt <= '0;
        else              col_cnt <= col_cnt + PER_W'(1);
    end

endmodule

// File: rtl/woi_row_seq.sv
module woi_row_seq
    import woi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             row_end,
    input  logic [SEQ_W-1:0] seq_len,
    output logic [SEQ_W-1:0] row_idx,
    output logic             frame_end
);

    logic last_row;

    assign last_row  = (row_idx == seq_len - SEQ_W'(1));
    assign frame_end = row_end && last_row;

    always_ff @(posedge clk) begin
        if (rst || !run)    row_idx <= '0;
        else if (frame_end) row_idx <= '0;
        else if (row_end)   row_idx <= row_idx + SEQ_W'(1);
    end

endmodule

// File: rtl/woi_scan_gen.sv
module woi_scan_gen
    import woi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [ROW_W-1:0] win_row_start,
    input  logic [COL_W-1:0] win_col_start,
    input  logic [ROW_W-1:0] win_height,
    input  logic [COL_W-1:0] win_width,
    input  logic [ROW_W-1:0] virt_depth,
    input  logic [COL_W-1:0] virt_width,
    input  logic [SH_W-1:0]  shs_width,
    input  logic [SH_W-1:0]  shr_width,
    input  logic [1:0]       row_skip,
    input  logic [1:0]       col_skip,
    input  logic [INT_W-1:0] int_rows,
    input  logic             single_mode,
    input  logic             strobe_en,
    input  logic             sync_in,
    input  logic             stop_req,
    output logic             rd_en,
    output logic [ROW_W-1:0] row_addr,
    output logic [COL_W-1:0] col_addr,
    output logic             rst_en,
    output logic [ROW_W-1:0] rst_row,
    output logic             frame_done,
    output logic             strobe
);

    scan_st_e         st_q;
    scan_geom_t       geom_q;
    logic [SEQ_W-1:0] rows_q, seq_len_q, int_q, row_idx;
    logic [PER_W-1:0] period_q, col_cnt;
    logic             run, row_end, frame_end, start_idle, keep_going, load;

    assign run        = (st_q == ST_RUN);
    assign start_idle = !run && (single_mode ? sync_in : !stop_req);
    assign keep_going = !geom_q.single && !stop_req;
    assign load       = start_idle || (frame_end && keep_going);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (start_idle)               st_q <= ST_RUN;
                default: if (frame_end && !keep_going) st_q <= ST_IDLE;
            endcase
        end
    end

    woi_cfg_latch u_cfg (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .row_start (win_row_start),
        .col_start (win_col_start),
        .height    (win_height),
        .width     (win_width),
        .depth     (virt_depth),
        .vwidth    (virt_width),
        .shs       (shs_width),
        .shr       (shr_width),
        .sub_row   (row_skip),
        .sub_col   (col_skip),
        .int_rows  (int_rows),
        .single    (single_mode),
        .strobe_on (strobe_en),
        .geom_q    (geom_q),
        .rows_q    (rows_q),
        .seq_len_q (seq_len_q),
        .int_q     (int_q),
        .period_q  (period_q)
    );

    woi_col_timer u_col (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .period  (period_q),
        .col_cnt (col_cnt),
        .row_end (row_end)
    );

    woi_row_seq u_row (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .row_end   (row_end),
        .seq_len   (seq_len_q),
        .row_idx   (row_idx),
        .frame_end (frame_end)
    );

    logic [SEQ_W-1:0] hgt, rs_sum, rs_off, rd_off;
    logic             rd_row_ok, rs_ok, col_ok;

    always_comb begin
        hgt    = SEQ_W'(geom_q.height);
        rs_sum = row_idx + int_q;
        if (geom_q.single) begin
            rs_off    = row_idx;
            rd_off    = row_idx - int_q;
            rd_row_ok = (row_idx >= int_q) && (rd_off < hgt);
        end else begin
            rs_off    = (rs_sum >= rows_q) ? (rs_sum - rows_q) : rs_sum;
            rd_off    = row_idx;
            rd_row_ok = (row_idx < hgt);
        end
        rd_row_ok = rd_row_ok && tile_keep(rd_off[3:0], geom_q.sub_row);
        rs_ok     = (rs_off < hgt) && tile_keep(rs_off[3:0], geom_q.sub_row);
        col_ok    = (col_cnt < PER_W'(geom_q.width)) &&
                    tile_keep(col_cnt[3:0], geom_q.sub_col);
    end

    assign rd_en      = run && rd_row_ok && col_ok;
    assign row_addr   = rd_en ? (geom_q.row_start + rd_off[ROW_W-1:0]) : '0;
    assign col_addr   = rd_en ? (geom_q.col_start + col_cnt[COL_W-1:0]) : '0;
    assign rst_en     = run && (col_cnt == '0) && rs_ok;
    assign rst_row    = rst_en ? (geom_q.row_start + rs_off[ROW_W-1:0]) : '0;
    assign frame_done = frame_end;
    assign strobe     = run && geom_q.single && geom_q.strobe_on &&
                        (row_idx >= hgt) && ((row_idx + SEQ_W'(1)) < int_q);

endmodule

// File: rtl/woi_scan_chk.sv
module woi_scan_chk
    import woi_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             stop_req,
    input scan_geom_t       geom_q,
    input logic             rd_en,
    input logic [ROW_W-1:0] row_addr,
    input logic [COL_W-1:0] col_addr,
    input logic             rst_en,
    input logic             frame_done,
    input logic             strobe
);

    p_col_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (col_addr >= geom_q.col_start) &&
                  ((col_addr - geom_q.col_start) < geom_q.width));

    p_row_in_window_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (row_addr >= geom_q.row_start) &&
                  ((row_addr - geom_q.row_start) < geom_q.height));

    p_rst_single_clock_r5: assert property (@(posedge clk) disable iff (rst)
        rst_en |=> !rst_en);

    p_done_single_clock_r1: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !frame_done);

    p_stop_at_boundary_r7: assert property (@(posedge clk) disable iff (rst)
        (frame_done && stop_req) |=> !run);

    p_strobe_no_read_r9: assert property (@(posedge clk) disable iff (rst)
        strobe |-> !rd_en);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !run |-> (!rd_en && !rst_en && !strobe && !frame_done));

endmodule

bind woi_scan_gen woi_scan_chk u_scan_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (run),
    .stop_req   (stop_req),
    .geom_q     (geom_q),
    .rd_en      (rd_en),
    .row_addr   (row_addr),
    .col_addr   (col_addr),
    .rst_en     (rst_en),
    .frame_done (frame_done),
    .strobe     (strobe)
);

// File: tb/tb_woi_scan_gen.sv
module tb_woi_scan_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic [10:0] win_row_start, win_col_start, win_height, win_width;
    logic [10:0] virt_depth, virt_width;
    logic [7:0]  shs_width, shr_width;
    logic [1:0]  row_skip, col_skip;
    logic [12:0] int_rows;
    logic        single_mode, strobe_en, sync_in, stop_req;
    logic        rd_en, rst_en, frame_done, strobe;
    logic [10:0] row_addr, col_addr, rst_row;

    always #5 clk = ~clk;

    woi_scan_gen dut (
        .clk(clk), .rst(rst),
        .win_row_start(win_row_start), .win_col_start(win_col_start),
        .win_height(win_height), .win_width(win_width),
        .virt_depth(virt_depth), .virt_width(virt_width),
        .shs_width(shs_width), .shr_width(shr_width),
        .row_skip(row_skip), .col_skip(col_skip), .int_rows(int_rows),
        .single_mode(single_mode), .strobe_en(strobe_en),
        .sync_in(sync_in), .stop_req(stop_req),
        .rd_en(rd_en), .row_addr(row_addr), .col_addr(col_addr),
        .rst_en(rst_en), .rst_row(rst_row),
        .frame_done(frame_done), .strobe(strobe)
    );

    typedef struct { int row; int col; } rd_item_t;
    typedef struct { int period; int strobe_clks; bit chk_period; } frm_item_t;

    rd_item_t  rd_q[$];
    int        rst_q[$];
    frm_item_t frm_q[$];

    int    n_chk = 0, n_fail = 0;
    int    fd_count = 0, cyc_since = 0, strobe_cnt = 0, ev_cnt = 0;
    string cur_req = "R3";
    bit    finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit keep(input int k, input int f);
        return ((k >> 1) & ((1 << f) - 1)) == 0;
    endfunction

    // scoreboard driver: expected events of one frame from current settings
    task automatic push_frame(input bit chk_period);
        int h, w, rows, per, seq, ie, off, rd_o;
        bit ok;
        frm_item_t fi;
        h    = win_height;
        w    = win_width;
        rows = ((virt_depth > win_height) ? int'(virt_depth) : h) + 1;
        per  = ((virt_width > win_width) ? int'(virt_width) : w)
               + shs_width + shr_width + 19;
        ie   = single_mode ? int'(int_rows)
                           : ((int'(int_rows) > rows - 1) ? rows - 1 : int'(int_rows));
        seq  = single_mode ? ie + rows : rows;
        for (int g = 0; g < seq; g++) begin
            off = single_mode ? g : ((g + ie) % rows);
            if (off < h && keep(off, row_skip)) rst_q.push_back(win_row_start + off);
            if (single_mode) begin
                ok = (g >= ie) && (g - ie < h);
                rd_o = g - ie;
            end else begin
                ok = g < h;
                rd_o = g;
            end
            if (ok && keep(rd_o, row_skip))
                for (int c = 0; c < w; c++)
                    if (keep(c, col_skip))
                        rd_q.push_back('{row: win_row_start + rd_o, col: win_col_start + c});
        end
        fi.period      = per * rows;
        fi.strobe_clks = (single_mode && strobe_en && (ie - 1 - h) > 0) ? (ie - 1 - h) * per : 0;
        fi.chk_period  = chk_period;
        frm_q.push_back(fi);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && !finished) begin
            rd_item_t  e;
            frm_item_t f;
            cyc_since++;
            if (strobe) strobe_cnt++;
            if (rd_en) begin
                ev_cnt++;
                if (rd_q.size() == 0) chk(1'b0, cur_req, "unexpected read row", row_addr, -1);
                else begin
                    e = rd_q.pop_front();
                    chk(row_addr == e.row, cur_req, "read row", row_addr, e.row);
                    chk(col_addr == e.col, cur_req, "read col", col_addr, e.col);
                end
            end else begin
                if (row_addr != 0 || col_addr != 0)
                    chk(1'b0, "R3", "address while idle", row_addr + col_addr, 0);
            end
            if (rst_en) begin
                ev_cnt++;
                if (rst_q.size() == 0) chk(1'b0, "R5", "unexpected reset row", rst_row, -1);
                else begin
                    int er;
                    er = rst_q.pop_front();
                    chk(rst_row == er, (cur_req == "R8") ? "R8" : "R5", "reset row", rst_row, er);
                end
            end
            if (frame_done) begin
                if (frm_q.size() == 0) chk(1'b0, "R1", "unexpected frame_done", fd_count, -1);
                else begin
                    f = frm_q.pop_front();
                    if (f.chk_period)
                        chk(cyc_since == f.period, "R1", "frame period", cyc_since, f.period);
                    chk(strobe_cnt == f.strobe_clks, "R9", "strobe clocks", strobe_cnt, f.strobe_clks);
                end
                cyc_since  = 0;
                strobe_cnt = 0;
                fd_count++;
            end
        end
    end

    task automatic check_drained(input string req);
        chk(rd_q.size() == 0, req, "reads left", rd_q.size(), 0);
        chk(rst_q.size() == 0, req, "resets left", rst_q.size(), 0);
        chk(frm_q.size() == 0, req, "frames left", frm_q.size(), 0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int base;
        rst = 1'b1; stop_req = 1'b1; sync_in = 1'b0;
        single_mode = 1'b0; strobe_en = 1'b0;
        win_row_start = 11'd3; win_col_start = 11'd8;
        win_height = 11'd6; win_width = 11'd4;
        virt_depth = 11'd7; virt_width = 11'd5;
        shs_width = 8'd1; shr_width = 8'd1;
        row_skip = 2'd0; col_skip = 2'd0; int_rows = 13'd2;

        // R11: outputs low in reset
        repeat (4) begin
            @(negedge clk);
            chk(!rd_en && !rst_en && !frame_done && !strobe, "R11", "outputs in reset",
                {rd_en, rst_en, frame_done, strobe}, 0);
        end
        @(negedge clk) rst = 1'b0;
        repeat (40) @(negedge clk);
        chk(ev_cnt == 0, "R11", "activity while idle after reset", ev_cnt, 0);

        // R3 R5 R6 R7 R10 R1: free-running, three frames, stop + write mid-frame
        cur_req = "R3";
        push_frame(1'b0); push_frame(1'b1); push_frame(1'b1);
        base = fd_count;
        stop_req = 1'b0;
        wait (fd_count == base + 2);
        @(negedge clk);
        @(negedge clk);
        win_width = 11'd2; win_height = 11'd1; virt_width = 11'd40;  // R10: not for this frame
        stop_req = 1'b1;                                              // R7: end of frame only
        wait (fd_count == base + 3);
        repeat (60) @(negedge clk);
        check_drained("R7");

        // R2 R4: virtual sizes below window, exposure clamp, tile skip 1/1
        cur_req = "R4";
        win_row_start = 11'd0; win_col_start = 11'd0;
        win_height = 11'd8; win_width = 11'd8;
        virt_depth = 11'd3; virt_width = 11'd4;
        shs_width = 8'd2; shr_width = 8'd3;
        row_skip = 2'd1; col_skip = 2'd1; int_rows = 13'd20;
        push_frame(1'b0); push_frame(1'b1);   // R2: period 32*9
        base = fd_count;
        stop_req = 1'b0;
        wait (fd_count == base + 1);
        @(negedge clk);
        @(negedge clk);
        stop_req = 1'b1;
        wait (fd_count == base + 2);
        repeat (40) @(negedge clk);
        check_drained("R2");

        // R4: coarse skips, single frame (stop raised right after start, R7)
        win_height = 11'd16; win_width = 11'd16;
        virt_depth = 11'd0; virt_width = 11'd0;
        shs_width = 8'd0; shr_width = 8'd0;
        row_skip = 2'd2; col_skip = 2'd3; int_rows = 13'd1;
        win_row_start = 11'd40; win_col_start = 11'd100;
        push_frame(1'b0);
        base = fd_count;
        stop_req = 1'b0;
        @(negedge clk);
        stop_req = 1'b1;
        wait (fd_count == base + 1);
        repeat (40) @(negedge clk);
        check_drained("R4");

        // R8 R9: triggered sequence with strobe, second sync ignored
        cur_req = "R8";
        single_mode = 1'b1; strobe_en = 1'b1;
        win_row_start = 11'd100; win_col_start = 11'd20;
        win_height = 11'd6; win_width = 11'd3;
        virt_depth = 11'd6; virt_width = 11'd3;
        shs_width = 8'd1; shr_width = 8'd1;
        row_skip = 2'd0; col_skip = 2'd0; int_rows = 13'd10;
        repeat (20) @(negedge clk);
        chk(ev_cnt > 0 && rd_q.size() == 0, "R8", "no start without sync", rd_q.size(), 0);
        push_frame(1'b0);      // strobe 3 rows * 24 clocks
        base = fd_count;
        sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
        repeat (100) @(negedge clk);
        sync_in = 1'b1;        // ignored while running
        @(negedge clk) sync_in = 1'b0;
        wait (fd_count == base + 1);
        repeat (500) @(negedge clk);
        check_drained("R8");

        // R9: strobe disabled, short exposure
        strobe_en = 1'b0; int_rows = 13'd3;
        push_frame(1'b0);
        base = fd_count;
        sync_in = 1'b1;
        @(negedge clk) sync_in = 1'b0;
        wait (fd_count == base + 1);
        repeat (60) @(negedge clk);
        check_drained("R9");

        finish_run();
    end

endmodule